// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave port that lets an external master read and write a bank of 16-bit configuration registers. The master drives an active-low select, a serial clock and a data line. The slave returns read data on either the same data line or a separate output line. The choice between these two is set by a static input, `threeWire`. All pin activity is sampled by the block's own system clock through two-stage synchronizers, so the serial clock must run well below that clock.

Each transaction is 32 serial clocks long and uses mode 0: a bit is captured on the rising edge and the next bit is launched on the falling edge. The 16-bit instruction comes first, MSB first. Bit 15 is the command (1 = write, 0 = read) and bits 14:11 are reserved. Bits 10:6 give the block and bits 5:0 give the register, which together form an 11-bit address. A 16-bit data word follows the instruction. Transactions may follow each other with no gap while select stays low. Only the first `BLOCKS` blocks (default 2, 64 registers each) hold storage. The data-line driver is shown as a value plus enable pair, for a pad ring to turn into a tri-state buffer.

Top module: `spi_reg_slave`

## Requirements
- R1: While select (`spiEnN`) is high, both output enables are low and the bit counter restarts. After reset, every register reads back 0 and both enables are low.
- R2: A 32-clock write (bit 15 = 1, bits 14:11 = 0) stores the 16 data bits into the addressed register once the last data bit is captured. A later read of that register returns the stored value.
- R3: A read (bit 15 = 0) returns the addressed register MSB first. The MSB is driven from the falling edge that follows the 16th instruction bit, so it is valid at the first data rising edge. The drivers switch on only after a serial clock falling edge.
- R4: With `threeWire` = 0, read data appears on `sdoOut` with `sdoOe` high during the 16 data clocks, and `sdioOe` is never high.
- R5: With `threeWire` = 1, read data appears on `sdioOut` with `sdioOe` high during the 16 data clocks only, and `sdoOe` is never high.
- R6: A write whose bits 14:11 are not all zero changes no register.
- R7: A transaction ended by select rising before its 32nd clock changes no register.
- R8: With select held low, consecutive 32-clock transactions (writes and reads in any mix) are each decoded from their own instruction.
- R9: The address is block = bits 10:6 and register = bits 5:0. A write to a block at or above `BLOCKS` is dropped and does not alias onto stored registers. A read from such a block returns 0.
- R10: No output enable is high during any instruction phase or during the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| threeWire | input | 1 | Static mode: 1 = read data on the shared data line, 0 = on the separate output |
| spiEnN | input | 1 | Active-low select from the master |
| spiClk | input | 1 | Serial clock from the master, idle low |
| sdioIn | input | 1 | Shared data line, input side |
| sdioOut | output | 1 | Shared data line, output value (0 when not enabled) |
| sdioOe | output | 1 | Output enable for the shared data line |
| sdoOut | output | 1 | Separate data output value (0 when not enabled) |
| sdoOe | output | 1 | Output enable for the separate data output |

## Verification
The assertions check four things on every system clock. The two drivers are never enabled together, and each stays off in the mode that does not use it. Both drivers are released in the cycle after select is seen high. A driver switches on only in the cycle after a falling-edge load. The stored values are left to the bench scenarios, since no per-cycle property can show them: the MSB-first read word, write commit after exactly 32 clocks, reserved-bit and aborted writes being dropped, the unimplemented-block behaviour and back-to-back framing.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int WORD_W  = 16;
  localparam int FRAME_W = 2 * WORD_W;
  localparam int REG_FIELD_W = 6;
  localparam int BLK_FIELD_W = 5;

  // Strobes from the control to the datapath, one system clock wide
  typedef struct packed {
    logic shiftIn;      // capture one serial bit
    logic instrLatch;   // instruction word complete
    logic writeCommit;  // data word complete on a valid write
    logic loadOut;      // falling edge after instruction: load read word
    logic shiftOut;     // falling edge inside read data phase
    logic outStop;      // release output drivers
  } spiStrobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int FRAME = FRAME_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiEnN,
  input  logic       spiClk,
  input  logic       instrCmd,
  input  logic       instrResvOk,
  output logic       deselected,
  output spiStrobe_t strobe
);

  localparam int HALF  = FRAME / 2;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(FRAME - 1);

  logic enMeta, enSync;
  logic clkMeta, clkSync, clkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic selected, riseEdge, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMeta  <= 1'b1;
      enSync  <= 1'b1;
      clkMeta <= 1'b0;
      clkSync <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      enMeta  <= spiEnN;
      enSync  <= enMeta;
      clkMeta <= spiClk;
      clkSync <= clkMeta;
      clkPrev <= clkSync;
    end
  end

  assign selected   = !enSync;
  assign deselected = enSync;
  assign riseEdge   = selected && clkSync && !clkPrev;
  assign fallEdge   = selected && !clkSync && clkPrev;

  // Counts rising edges; wraps every frame so back-to-back frames realign
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (!selected) bitCnt <= '0;
    else if (riseEdge)  bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe             = '0;
    strobe.shiftIn     = riseEdge;
    strobe.instrLatch  = riseEdge && (bitCnt == LAST_INSTR);
    strobe.writeCommit = riseEdge && (bitCnt == LAST_DATA) && instrCmd && instrResvOk;
    strobe.loadOut     = fallEdge && (bitCnt == FIRST_DATA) && !instrCmd;
    strobe.shiftOut    = fallEdge && (bitCnt > FIRST_DATA);
    strobe.outStop     = !selected || (fallEdge && (bitCnt == '0));
  end

endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int BLOCKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdioIn,
  input  spiStrobe_t strobe,
  output logic       instrCmd,
  output logic       instrResvOk,
  output logic       outBit,
  output logic       outEn
);

  localparam int REGS = 1 << REG_FIELD_W;
  localparam logic [BLK_FIELD_W:0] BLK_LIMIT = (BLK_FIELD_W + 1)'(BLOCKS);

  logic dataMeta, dataSync;
  logic [WORD_W-1:0] shiftReg, instrReg, outShift, nextWord, readWord;
  logic [BLK_FIELD_W-1:0] blkField;
  logic [REG_FIELD_W-1:0] regField;
  logic blkHit;
  logic [WORD_W-1:0] bankRead [BLOCKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataMeta <= 1'b0;
      dataSync <= 1'b0;
    end else begin
      dataMeta <= sdioIn;
      dataSync <= dataMeta;
    end
  end

  assign nextWord = {shiftReg[WORD_W-2:0], dataSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      instrReg <= '0;
    end else begin
      if (strobe.shiftIn)    shiftReg <= nextWord;
      if (strobe.instrLatch) instrReg <= nextWord;
    end
  end

  assign instrCmd    = instrReg[15];
  assign instrResvOk = (instrReg[14:11] == 4'b0000);
  assign blkField    = instrReg[10:6];
  assign regField    = instrReg[5:0];
  assign blkHit      = {1'b0, blkField} < BLK_LIMIT;

  // One storage bank per implemented block
  for (genvar b = 0; b < BLOCKS; b++) begin : gBank
    logic [WORD_W-1:0] bank [REGS];
    logic bankWe;
    assign bankWe = strobe.writeCommit && blkHit && (32'(blkField) == b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < REGS; r++) bank[r] <= '0;
      end else if (bankWe) begin
        bank[regField] <= nextWord;
      end
    end

    assign bankRead[b] = bank[regField];
  end

  always_comb begin
    readWord = '0;
    for (int b = 0; b < BLOCKS; b++) begin
      if (blkHit && (32'(blkField) == b)) readWord = bankRead[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outEn    <= 1'b0;
    end else begin
      if (strobe.outStop)      outEn <= 1'b0;
      else if (strobe.loadOut) outEn <= 1'b1;
      if (strobe.loadOut)       outShift <= readWord;
      else if (strobe.shiftOut) outShift <= {outShift[WORD_W-2:0], 1'b0};
    end
  end

  assign outBit = outShift[WORD_W-1];

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int BLOCKS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic threeWire,
  input  logic spiEnN,
  input  logic spiClk,
  input  logic sdioIn,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdoOut,
  output logic sdoOe
);

  spiStrobe_t strobe;
  logic instrCmd, instrResvOk, deselected, outBit, outEn;

  spi_reg_ctrl #(.FRAME(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .spiEnN(spiEnN), .spiClk(spiClk),
    .instrCmd(instrCmd), .instrResvOk(instrResvOk),
    .deselected(deselected), .strobe(strobe)
  );

  spi_reg_datapath #(.BLOCKS(BLOCKS)) uData (
    .clk(clk), .rstN(rstN), .sdioIn(sdioIn), .strobe(strobe),
    .instrCmd(instrCmd), .instrResvOk(instrResvOk),
    .outBit(outBit), .outEn(outEn)
  );

  assign sdioOe  = outEn && threeWire;
  assign sdoOe   = outEn && !threeWire;
  assign sdioOut = sdioOe && outBit;
  assign sdoOut  = sdoOe && outBit;

endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker
  import spi_reg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       threeWire,
  input logic       sdioOe,
  input logic       sdoOe,
  input logic       deselected,
  input spiStrobe_t strobe
);

  assert_no_dual_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOe));

  assert_sdio_quiet_4wire_R4: assert property (@(posedge clk) disable iff (!rstN)
    !threeWire |-> !sdioOe);

  assert_sdo_quiet_3wire_R5: assert property (@(posedge clk) disable iff (!rstN)
    threeWire |-> !sdoOe);

  assert_release_on_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    deselected |=> (!sdioOe && !sdoOe));

  assert_drive_after_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdioOe || sdoOe) |-> $past(strobe.loadOut));

endmodule

bind spi_reg_slave spi_reg_checker uChk (
  .clk(clk), .rstN(rstN), .threeWire(threeWire), .sdioOe(sdioOe),
  .sdoOe(sdoOe), .deselected(deselected), .strobe(strobe)
);

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;

  localparam int BLOCKS  = 2;
  localparam int HALF_NS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic threeWire = 1'b0;
  logic spiEnN = 1'b1;
  logic spiClk = 1'b0;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [15:0] model [BLOCKS*64];
  logic [15:0] expQ[$];
  logic [15:0] gotQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  spi_reg_slave #(.BLOCKS(BLOCKS)) dut (
    .clk(clk), .rstN(rstN), .threeWire(threeWire), .spiEnN(spiEnN),
    .spiClk(spiClk), .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe),
    .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic selectDev();
    spiEnN = 1'b0;
    #HALF_NS;
  endtask

  task automatic deselectDev();
    spiClk = 1'b0;
    #HALF_NS;
    spiEnN = 1'b1;
    #(4 * HALF_NS);
  endtask

  // Master driver: shifts one frame, captures read bits, pushes scoreboard items
  task automatic xfer(input logic cmd, input logic [3:0] resv, input logic [4:0] blk,
                      input logic [5:0] rg, input logic [15:0] wdata, input int nclk,
                      input string tag);
    logic [31:0] frame;
    logic [15:0] got;
    logic [15:0] exp;
    bit driveBad;
    frame = {cmd, resv, blk, rg, wdata};
    got = '0;
    driveBad = 1'b0;
    exp = (32'(blk) < BLOCKS) ? model[32'(blk) * 64 + 32'(rg)] : 16'h0000;
    for (int i = 0; i < nclk; i++) begin
      sdioIn = frame[31 - i];
      #HALF_NS;
      spiClk = 1'b1;
      if (!cmd && i >= 16) begin
        if (threeWire) begin
          got = {got[14:0], sdioOut};
          if (!sdioOe || sdoOe) driveBad = 1'b1;
        end else begin
          got = {got[14:0], sdoOut};
          if (!sdoOe || sdioOe) driveBad = 1'b1;
        end
      end else if (sdioOe || sdoOe) begin
        driveBad = 1'b1;
      end
      #HALF_NS;
      spiClk = 1'b0;
    end
    sdioIn = 1'b0;
    if (cmd) check(!driveBad, "R10 driver during write/instruction", {15'b0, driveBad}, 16'h0);
    else     check(!driveBad, threeWire ? "R5 drive pattern" : "R4 drive pattern", {15'b0, driveBad}, 16'h0);
    if (nclk == 32) begin
      if (cmd) begin
        if (resv == 4'b0 && 32'(blk) < BLOCKS) model[32'(blk) * 64 + 32'(rg)] = wdata;
      end else begin
        expQ.push_back(exp);
        gotQ.push_back(got);
        tagQ.push_back(tag);
      end
    end
  endtask

  // Monitor: compares captured read words against expected items
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        logic [15:0] g, e;
        string t;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BLOCKS * 64; i++) model[i] = 16'h0000;
    #1;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    #20;
    check(!sdioOe && !sdoOe, "R1 reset drivers", {14'b0, sdioOe, sdoOe}, 16'h0);

    // R1 reset contents, R2 write then read, R4 four-wire return
    threeWire = 1'b0;
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R1 reset value"); deselectDev();
    selectDev(); xfer(1'b1, 4'h0, 5'd0, 6'd5, 16'hA5C3, 32, "R2"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R2 R4 readback"); deselectDev();
    // R3 MSB first with edge bits, R9 top register of last block
    selectDev(); xfer(1'b1, 4'h0, 5'd1, 6'd63, 16'h8001, 32, "R9"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd1, 6'd63, 16'h0, 32, "R3 R9 msb-first"); deselectDev();

    // R5 three-wire return on the shared line
    threeWire = 1'b1;
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R5 readback"); deselectDev();
    selectDev(); xfer(1'b1, 4'h0, 5'd1, 6'd0, 16'h1234, 32, "R5"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd1, 6'd0, 16'h0, 32, "R5 second read"); deselectDev();

    // R8 back-to-back frames under one select
    selectDev();
    xfer(1'b1, 4'h0, 5'd0, 6'd10, 16'hFFFF, 32, "R8");
    xfer(1'b1, 4'h0, 5'd0, 6'd11, 16'h0F0F, 32, "R8");
    xfer(1'b0, 4'h0, 5'd0, 6'd10, 16'h0, 32, "R8 first read");
    xfer(1'b0, 4'h0, 5'd0, 6'd11, 16'h0, 32, "R8 second read");
    xfer(1'b0, 4'h0, 5'd1, 6'd63, 16'h0, 32, "R8 third read");
    deselectDev();

    // R6 reserved bits nonzero: write dropped
    threeWire = 1'b0;
    selectDev(); xfer(1'b1, 4'h4, 5'd0, 6'd5, 16'h1111, 32, "R6"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R6 unchanged"); deselectDev();

    // R7 aborted writes at 20 and 31 clocks
    selectDev(); xfer(1'b1, 4'h0, 5'd0, 6'd5, 16'h2222, 20, "R7"); deselectDev();
    selectDev(); xfer(1'b1, 4'h0, 5'd0, 6'd5, 16'h3333, 31, "R7"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R7 unchanged"); deselectDev();

    // R1 abort in the middle of a read releases the drivers
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd10, 16'h0, 24, "R1");
    spiClk = 1'b0; #HALF_NS; spiEnN = 1'b1; #(2 * HALF_NS);
    check(!sdioOe && !sdoOe, "R1 release after abort", {14'b0, sdioOe, sdoOe}, 16'h0);
    #(2 * HALF_NS);
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd10, 16'h0, 32, "R1 R8 frame realigned"); deselectDev();

    // R9 unimplemented block: no alias, reads zero
    selectDev(); xfer(1'b1, 4'h0, 5'd2, 6'd5, 16'hBEEF, 32, "R9"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd2, 6'd5, 16'h0, 32, "R9 empty block"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd0, 6'd5, 16'h0, 32, "R9 no alias"); deselectDev();
    threeWire = 1'b1;
    selectDev(); xfer(1'b1, 4'h0, 5'd31, 6'd63, 16'h7777, 32, "R9"); deselectDev();
    selectDev(); xfer(1'b0, 4'h0, 5'd1, 6'd63, 16'h0, 32, "R9 top block no alias"); deselectDev();

    #(4 * HALF_NS);
    check(expQ.size() == 0, "R8 scoreboard drained", 16'(expQ.size()), 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule